// File: doc/BRIEF.md
# Base-Point Scalar Multiplication Sequencer

This block is the control unit for computing R = k·G, where G is a fixed base point of an elliptic-curve group. It does no field arithmetic itself. Instead it drives an external point-arithmetic datapath through a simple command/done handshake. Each command asks the datapath to double the accumulator, to add the base point to it, or to convert it to affine form. The datapath answers each command with a result point. For additions it also answers with three flags that mark special inputs: accumulator at infinity, accumulator equal to G, and accumulator equal to −G.

The scalar is consumed from its most significant bit down to its least significant bit. Every bit costs one doubling followed by one addition. The addition runs whatever the bit is, and its result is kept only when the bit is 1. As a result, the command stream and the total cycle count do not depend on the scalar. The corner cases of the addition are settled by choosing among the formula output, the stored base point G, a stored constant H = 2·G, and the canonical infinity point. The sequencer never branches into other formulas for them.

The point at infinity is held as (X, Y, Z) = (1, 1, 0). Any point with Z = 0 counts as infinity, whatever its X and Y are. When all bits are consumed, the accumulator is sent for affine conversion. The affine pair is then presented together with a one-cycle done pulse.

Top module: `base_mul_seq`

## Requirements
- R1: After a start is accepted, the block issues one doubling command (op code 1) and then one addition command (op code 2) for each scalar bit, taking the bits from bit KW-1 down to bit 0. It ends with one affine-conversion command (op code 3). Every command is a single-cycle pulse of `dp_cmd_valid` with operands on `dp_px/dp_py/dp_pz`. The affine pair returned by the datapath equals k·G, reduced modulo the group order.
- R2: A run always issues exactly 2·KW+1 commands. With a fixed datapath latency, the time from start to done is the same for every scalar value.
- R3: The accumulator starts every run at infinity (1, 1, 0). When a doubling is requested on an accumulator whose Z is 0, the committed accumulator keeps Z = 0, whatever Z the datapath returns.
- R4: When the infinity flag is set on an addition result and the bit is 1, the accumulator becomes (Gx, Gy, 1). This flag takes priority over the other two flags.
- R5: When the equal flag is set (and the infinity flag is not) and the bit is 1, the accumulator becomes the stored constant (Hx, Hy, 1). So k = 2 and k = n + 2 give the same result.
- R6: When the opposite flag is set (and neither of the other flags is) and the bit is 1, the accumulator becomes infinity (1, 1, 0). So k = n gives an all-zero affine result.
- R7: When no flag is set and the bit is 1, the datapath's formula output is committed. When the bit is 0, the accumulator is left unchanged by the addition.
- R8: `done` is high for exactly one cycle, in the cycle after the conversion result returns. `res_x/res_y` change only at that point and hold their values until the next run completes.
- R9: `start` is ignored while `busy` is high. A run then completes with the scalar it began with, and it produces one done pulse only.
- R10: After reset, `busy`, `done`, `dp_cmd_valid`, `res_x` and `res_y` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a multiplication when idle |
| scalar | input | KW | Scalar k, sampled when start is accepted |
| busy | output | 1 | A multiplication is in progress |
| done | output | 1 | One-cycle pulse: affine result is valid |
| res_x | output | CW | Affine X of k·G (0 when the result is infinity) |
| res_y | output | CW | Affine Y of k·G (0 when the result is infinity) |
| dp_cmd_valid | output | 1 | Command pulse to the datapath |
| dp_cmd_op | output | 2 | Command code: 1 double, 2 add G, 3 affine conversion |
| dp_px | output | CW | Accumulator X operand |
| dp_py | output | CW | Accumulator Y operand |
| dp_pz | output | CW | Accumulator Z operand |
| dp_done | input | 1 | Datapath result valid (one cycle) |
| dp_rx | input | CW | Result X (affine X for conversion) |
| dp_ry | input | CW | Result Y (affine Y for conversion) |
| dp_rz | input | CW | Result Z |
| dp_flag_inf | input | 1 | Addition input: accumulator at infinity |
| dp_flag_same | input | 1 | Addition input: accumulator equals G |
| dp_flag_neg | input | 1 | Addition input: accumulator equals −G |

## Verification
The bench drives the sequencer against a datapath model in which a point stands for its discrete logarithm modulo a small prime order, so the expected result of any scalar is just k mod n. The model returns garbage for the formula output whenever a flag is set, and garbage with nonzero Z when it is asked to double infinity. A wrong selection or a missing infinity guard therefore changes the answer instead of hiding. The scalars tried are 0, 1, 2, n−1, n, n+1 and n+2, an all-ones scalar, and several mid-range values. Of these, k = n walks through the opposite case, k = n+2 walks through the equal case, and the small scalars exercise the leading-zero stretch where the infinity flag and the equal flag are both raised at once. A start pulse in the middle of a run, and a latency comparison across all runs, separate scalar-dependent control from the intended constant-time behaviour.

// File: rtl/bms_pkg.sv
package bms_pkg;

  // Datapath command codes (fixed by the interface)
  typedef enum logic [1:0] {
    CMD_NONE = 2'd0,
    CMD_DBL  = 2'd1,
    CMD_ADD  = 2'd2,
    CMD_AFF  = 2'd3
  } cmd_e;

  // Sequencer states: each command has an issue state and a wait state
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_DBL   = 3'd1,
    ST_DBL_W = 3'd2,
    ST_ADD   = 3'd3,
    ST_ADD_W = 3'd4,
    ST_AFF   = 3'd5,
    ST_AFF_W = 3'd6
  } seq_state_e;

  // Source chosen for the committed addition result
  typedef enum logic [1:0] {
    PICK_FORMULA = 2'd0,
    PICK_BASE    = 2'd1,
    PICK_TWICE   = 2'd2,
    PICK_INF     = 2'd3
  } pick_e;

  // Corner-case priority: infinity, then equal, then opposite, then formula
  function automatic pick_e corner_pick(input logic f_inf, input logic f_same,
                                        input logic f_neg);
    if (f_inf)       return PICK_BASE;
    else if (f_same) return PICK_TWICE;
    else if (f_neg)  return PICK_INF;
    else             return PICK_FORMULA;
  endfunction

  // Number of datapath commands in one complete run
  function automatic int unsigned run_cmd_count(input int unsigned kw);
    return 2 * kw + 1;
  endfunction

endpackage

// File: rtl/bms_bit_scan.sv
// Holds the scalar and presents its bits most significant first.
module bms_bit_scan #(
  parameter int unsigned KW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [KW-1:0] k_in,
  input  logic          advance,
  output logic          bit_now,
  output logic          last_bit
);
  localparam int unsigned IW = (KW > 1) ? $clog2(KW) : 1;
  localparam logic [IW-1:0] TOP_IDX = IW'(KW - 1);

  logic [KW-1:0] k_sh;
  logic [IW-1:0] idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      k_sh <= '0;
      idx  <= '0;
    end else if (load) begin
      k_sh <= k_in;
      idx  <= TOP_IDX;
    end else if (advance) begin
      k_sh <= k_sh << 1;
      if (idx != '0) idx <= idx - 1'b1;
    end
  end

  assign bit_now  = k_sh[KW-1];
  assign last_bit = (idx == '0);
endmodule

// File: rtl/bms_ctrl.sv
// Command sequencer: double, add, ..., convert, with one-cycle events.
module bms_ctrl
  import bms_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       dp_done,
  input  logic       last_bit,
  output logic       cmd_valid,
  output logic [1:0] cmd_op,
  output logic       ev_accept,
  output logic       ev_dbl_ret,
  output logic       ev_add_ret,
  output logic       ev_aff_ret,
  output logic       busy
);
  seq_state_e st, st_nx;
  cmd_e       op;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= st_nx;
  end

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_IDLE:  if (start) st_nx = ST_DBL;
      ST_DBL:   st_nx = ST_DBL_W;
      ST_DBL_W: if (dp_done) st_nx = ST_ADD;
      ST_ADD:   st_nx = ST_ADD_W;
      ST_ADD_W: if (dp_done) st_nx = last_bit ? ST_AFF : ST_DBL;
      ST_AFF:   st_nx = ST_AFF_W;
      ST_AFF_W: if (dp_done) st_nx = ST_IDLE;
      default:  st_nx = ST_IDLE;
    endcase
  end

  always_comb begin
    unique case (st)
      ST_DBL:  op = CMD_DBL;
      ST_ADD:  op = CMD_ADD;
      ST_AFF:  op = CMD_AFF;
      default: op = CMD_NONE;
    endcase
  end

  assign cmd_valid  = (op != CMD_NONE);
  assign cmd_op     = op;
  assign ev_accept  = (st == ST_IDLE)  && start;
  assign ev_dbl_ret = (st == ST_DBL_W) && dp_done;
  assign ev_add_ret = (st == ST_ADD_W) && dp_done;
  assign ev_aff_ret = (st == ST_AFF_W) && dp_done;
  assign busy       = (st != ST_IDLE);
endmodule

// File: rtl/bms_corner_pick.sv
// Chooses the point committed after an addition, coordinate by coordinate.
module bms_corner_pick
  import bms_pkg::*;
#(
  parameter int unsigned CW = 8,
  parameter logic [CW-1:0] GX = CW'(1),
  parameter logic [CW-1:0] GY = CW'(2),
  parameter logic [CW-1:0] HX = CW'(3),
  parameter logic [CW-1:0] HY = CW'(4)
) (
  input  logic          f_inf,
  input  logic          f_same,
  input  logic          f_neg,
  input  logic [CW-1:0] fx,
  input  logic [CW-1:0] fy,
  input  logic [CW-1:0] fz,
  output logic [CW-1:0] ox,
  output logic [CW-1:0] oy,
  output logic [CW-1:0] oz
);
  localparam logic [CW-1:0] ONE  = CW'(1);
  localparam logic [CW-1:0] ZERO = '0;

  // per coordinate: base point, doubled base point, infinity
  localparam logic [3*CW-1:0] BASE_PT  = {ONE,  GY,  GX};
  localparam logic [3*CW-1:0] TWICE_PT = {ONE,  HY,  HX};
  localparam logic [3*CW-1:0] INF_PT   = {ZERO, ONE, ONE};

  pick_e           src;
  logic [3*CW-1:0] form_pt;
  logic [3*CW-1:0] out_pt;

  assign src     = corner_pick(f_inf, f_same, f_neg);
  assign form_pt = {fz, fy, fx};

  for (genvar c = 0; c < 3; c++) begin : g_coord
    always_comb begin
      unique case (src)
        PICK_BASE:  out_pt[c*CW +: CW] = BASE_PT[c*CW +: CW];
        PICK_TWICE: out_pt[c*CW +: CW] = TWICE_PT[c*CW +: CW];
        PICK_INF:   out_pt[c*CW +: CW] = INF_PT[c*CW +: CW];
        default:    out_pt[c*CW +: CW] = form_pt[c*CW +: CW];
      endcase
    end
  end

  assign ox = out_pt[0 +: CW];
  assign oy = out_pt[CW +: CW];
  assign oz = out_pt[2*CW +: CW];
endmodule

// File: rtl/base_mul_seq.sv
// Base-point scalar multiplication sequencer (top).
module base_mul_seq #(
  parameter int unsigned KW = 10,
  parameter int unsigned CW = 8,
  parameter logic [CW-1:0] GX = CW'(1),
  parameter logic [CW-1:0] GY = CW'(8'hFE),
  parameter logic [CW-1:0] HX = CW'(2),
  parameter logic [CW-1:0] HY = CW'(8'hFD)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [KW-1:0] scalar,
  output logic          busy,
  output logic          done,
  output logic [CW-1:0] res_x,
  output logic [CW-1:0] res_y,
  output logic          dp_cmd_valid,
  output logic [1:0]    dp_cmd_op,
  output logic [CW-1:0] dp_px,
  output logic [CW-1:0] dp_py,
  output logic [CW-1:0] dp_pz,
  input  logic          dp_done,
  input  logic [CW-1:0] dp_rx,
  input  logic [CW-1:0] dp_ry,
  input  logic [CW-1:0] dp_rz,
  input  logic          dp_flag_inf,
  input  logic          dp_flag_same,
  input  logic          dp_flag_neg
);
  localparam logic [CW-1:0] ONE = CW'(1);

  // named internal events (observed by the checker)
  logic ev_accept, ev_dbl_ret, ev_add_ret, ev_aff_ret;
  logic bit_now, last_bit;

  logic [CW-1:0] acc_x, acc_y, acc_z;
  logic [CW-1:0] sel_x, sel_y, sel_z;
  logic          acc_at_inf;

  bms_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .dp_done    (dp_done),
    .last_bit   (last_bit),
    .cmd_valid  (dp_cmd_valid),
    .cmd_op     (dp_cmd_op),
    .ev_accept  (ev_accept),
    .ev_dbl_ret (ev_dbl_ret),
    .ev_add_ret (ev_add_ret),
    .ev_aff_ret (ev_aff_ret),
    .busy       (busy)
  );

  bms_bit_scan #(.KW(KW)) u_scan (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ev_accept),
    .k_in     (scalar),
    .advance  (ev_add_ret),
    .bit_now  (bit_now),
    .last_bit (last_bit)
  );

  bms_corner_pick #(.CW(CW), .GX(GX), .GY(GY), .HX(HX), .HY(HY)) u_pick (
    .f_inf  (dp_flag_inf),
    .f_same (dp_flag_same),
    .f_neg  (dp_flag_neg),
    .fx     (dp_rx),
    .fy     (dp_ry),
    .fz     (dp_rz),
    .ox     (sel_x),
    .oy     (sel_y),
    .oz     (sel_z)
  );

  assign acc_at_inf = (acc_z == '0);

  // accumulator: starts at infinity, doubling keeps infinity, add commits on 1
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_x <= ONE;
      acc_y <= ONE;
      acc_z <= '0;
    end else if (ev_accept) begin
      acc_x <= ONE;
      acc_y <= ONE;
      acc_z <= '0;
    end else if (ev_dbl_ret) begin
      if (acc_at_inf) begin
        acc_x <= ONE;
        acc_y <= ONE;
        acc_z <= '0;
      end else begin
        acc_x <= dp_rx;
        acc_y <= dp_ry;
        acc_z <= dp_rz;
      end
    end else if (ev_add_ret && bit_now) begin
      acc_x <= sel_x;
      acc_y <= sel_y;
      acc_z <= sel_z;
    end
  end

  // result registers and completion pulse
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_x <= '0;
      res_y <= '0;
      done  <= 1'b0;
    end else begin
      done <= ev_aff_ret;
      if (ev_aff_ret) begin
        res_x <= dp_rx;
        res_y <= dp_ry;
      end
    end
  end

  assign dp_px = acc_x;
  assign dp_py = acc_y;
  assign dp_pz = acc_z;
endmodule

// File: rtl/bms_checker.sv
// Property checker, bound into the sequencer top.
module bms_checker #(
  parameter int unsigned KW = 10,
  parameter int unsigned CW = 8,
  parameter logic [CW-1:0] GX = CW'(1),
  parameter logic [CW-1:0] GY = CW'(2),
  parameter logic [CW-1:0] HX = CW'(3),
  parameter logic [CW-1:0] HY = CW'(4)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic [CW-1:0] res_x,
  input logic [CW-1:0] res_y,
  input logic          dp_cmd_valid,
  input logic [CW-1:0] dp_px,
  input logic [CW-1:0] dp_py,
  input logic [CW-1:0] dp_pz,
  input logic          dp_flag_inf,
  input logic          dp_flag_same,
  input logic          dp_flag_neg,
  input logic          ev_accept,
  input logic          ev_dbl_ret,
  input logic          ev_add_ret,
  input logic          bit_now
);
  localparam logic [15:0] RUN_CMDS = 16'(bms_pkg::run_cmd_count(KW));

  logic [15:0] cmd_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cmd_cnt <= '0;
    else if (ev_accept)    cmd_cnt <= '0;
    else if (dp_cmd_valid) cmd_cnt <= cmd_cnt + 16'd1;
  end

  // R1: every command is a single-cycle pulse
  a_r1_cmd_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    dp_cmd_valid |=> !dp_cmd_valid);

  // R2: fixed command count per run
  a_r2_cmd_count: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cmd_cnt == RUN_CMDS));

  // R3: doubling never lifts the accumulator out of infinity
  a_r3_dbl_keeps_inf: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_dbl_ret && dp_pz == '0) |=> (dp_pz == '0));

  // R4: infinity flag wins and yields the base point
  a_r4_inf_gives_base: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_add_ret && bit_now && dp_flag_inf) |=>
      (dp_px == GX && dp_py == GY && dp_pz == CW'(1)));

  // R5: equal flag yields stored 2G
  a_r5_same_gives_twice: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_add_ret && bit_now && !dp_flag_inf && dp_flag_same) |=>
      (dp_px == HX && dp_py == HY && dp_pz == CW'(1)));

  // R6: opposite flag yields canonical infinity
  a_r6_neg_gives_inf: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_add_ret && bit_now && !dp_flag_inf && !dp_flag_same && dp_flag_neg) |=>
      (dp_px == CW'(1) && dp_py == CW'(1) && dp_pz == '0));

  // R7: a zero bit leaves the accumulator alone
  a_r7_zero_bit_skips: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_add_ret && !bit_now) |=>
      ($stable(dp_px) && $stable(dp_py) && $stable(dp_pz)));

  // R8: done is a one-cycle pulse and results only move with it
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r8_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(res_x) && $stable(res_y)));

  // R9: a run ends with the sequencer idle
  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

bind base_mul_seq bms_checker #(
  .KW(KW), .CW(CW), .GX(GX), .GY(GY), .HX(HX), .HY(HY)
) u_bms_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .busy         (busy),
  .done         (done),
  .res_x        (res_x),
  .res_y        (res_y),
  .dp_cmd_valid (dp_cmd_valid),
  .dp_px        (dp_px),
  .dp_py        (dp_py),
  .dp_pz        (dp_pz),
  .dp_flag_inf  (dp_flag_inf),
  .dp_flag_same (dp_flag_same),
  .dp_flag_neg  (dp_flag_neg),
  .ev_accept    (ev_accept),
  .ev_dbl_ret   (ev_dbl_ret),
  .ev_add_ret   (ev_add_ret),
  .bit_now      (bit_now)
);

// File: tb/test_base_mul_seq.sv
module test_base_mul_seq;
  localparam int unsigned KW = 10;
  localparam int unsigned CW = 8;
  localparam int unsigned NORD = 157;   // toy group order (prime)
  localparam int unsigned DP_LAT = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [KW-1:0] scalar = '0;
  logic busy, done, dp_cmd_valid;
  logic [CW-1:0] res_x, res_y, dp_px, dp_py, dp_pz;
  logic [1:0] dp_cmd_op;
  logic dp_done = 1'b0;
  logic [CW-1:0] dp_rx = '0, dp_ry = '0, dp_rz = '0;
  logic dp_flag_inf = 1'b0, dp_flag_same = 1'b0, dp_flag_neg = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  base_mul_seq #(.KW(KW), .CW(CW), .GX(8'h01), .GY(8'hFE), .HX(8'h02), .HY(8'hFD))
  i_base_mul_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .scalar(scalar), .busy(busy),
    .done(done), .res_x(res_x), .res_y(res_y), .dp_cmd_valid(dp_cmd_valid),
    .dp_cmd_op(dp_cmd_op), .dp_px(dp_px), .dp_py(dp_py), .dp_pz(dp_pz),
    .dp_done(dp_done), .dp_rx(dp_rx), .dp_ry(dp_ry), .dp_rz(dp_rz),
    .dp_flag_inf(dp_flag_inf), .dp_flag_same(dp_flag_same), .dp_flag_neg(dp_flag_neg)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // ---------------- toy datapath: a point is its discrete log m, X=m, Y=~m
  logic [1:0]    q_op;
  logic [CW-1:0] q_x, q_z;
  int            lat_cnt = 0;

  always @(posedge clk) begin
    dp_done <= 1'b0;
    if (dp_cmd_valid) begin
      q_op <= dp_cmd_op; q_x <= dp_px; q_z <= dp_pz;
      lat_cnt <= DP_LAT;
    end else if (lat_cnt != 0) begin
      lat_cnt <= lat_cnt - 1;
      if (lat_cnt == 1) begin
        int m;
        dp_done <= 1'b1;
        dp_flag_inf <= 1'b0; dp_flag_same <= 1'b0; dp_flag_neg <= 1'b0;
        case (q_op)
          2'd1: begin
            if (q_z == 0) begin   // garbage, nonzero Z, on doubling infinity
              dp_rx <= 8'h5A; dp_ry <= 8'hA5; dp_rz <= 8'h33;
            end else begin
              m = (2 * int'(q_x)) % NORD;
              dp_rx <= CW'(m); dp_ry <= ~CW'(m); dp_rz <= 8'd1;
            end
          end
          2'd2: begin
            dp_flag_inf  <= (q_z == 0);
            dp_flag_same <= (q_x == 8'd1);
            dp_flag_neg  <= (int'(q_x) == NORD - 1);
            if (q_z == 0 || q_x == 8'd1 || int'(q_x) == NORD - 1) begin
              dp_rx <= 8'h77; dp_ry <= 8'h88; dp_rz <= 8'h99;
            end else begin
              m = (int'(q_x) + 1) % NORD;
              dp_rx <= CW'(m); dp_ry <= ~CW'(m); dp_rz <= 8'd1;
            end
          end
          default: begin
            if (q_z == 0) begin dp_rx <= '0; dp_ry <= '0; end
            else          begin dp_rx <= q_x; dp_ry <= ~q_x; end
            dp_rz <= 8'd1;
          end
        endcase
      end
    end
  end

  // ---------------- scoreboard
  typedef struct {
    logic [CW-1:0] x;
    logic [CW-1:0] y;
    string         tag;
  } exp_t;
  exp_t exp_q[$];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // monitor: pops one expected item per done pulse
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) begin
        check(0, "R9", "unexpected done", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(res_x == e.x, e.tag, "res_x", int'(res_x), int'(e.x));
        check(res_y == e.y, e.tag, "res_y", int'(res_y), int'(e.y));
      end
    end
  end

  int ref_lat = -1;

  // driver: pushes k*G mod n, runs, checks run latency
  task automatic run_k(input int k, input string tag, input bit stray);
    exp_t e;
    int m, cyc;
    m = k % NORD;
    e.x = (m == 0) ? 8'd0 : CW'(m);
    e.y = (m == 0) ? 8'd0 : ~CW'(m);
    e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk);
    scalar = KW'(k); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (!done) begin
      if (stray && cyc == 7) begin   // R9: start during busy
        scalar = KW'(k + 3); start = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    if (ref_lat < 0) ref_lat = cyc;
    else check(cyc == ref_lat, "R2", "latency", cyc, ref_lat);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset values
    check(busy == 0, "R10", "busy", int'(busy), 0);
    check(done == 0, "R10", "done", int'(done), 0);
    check(dp_cmd_valid == 0, "R10", "dp_cmd_valid", int'(dp_cmd_valid), 0);
    check(res_x == 0 && res_y == 0, "R10", "res", int'({res_x, res_y}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 0, "R10", "busy after release", int'(busy), 0);

    run_k(0,          "R3 k=0",        0);
    run_k(1,          "R4 k=1",        0);
    run_k(2,          "R5 k=2",        0);
    run_k(NORD + 2,   "R5 k=n+2",      0);
    run_k(NORD,       "R6 k=n",        0);
    run_k(NORD + 1,   "R4 k=n+1",      0);
    run_k(NORD - 1,   "R7 k=n-1",      0);
    run_k(1023,       "R1 k=all-ones", 0);
    run_k(300,        "R7 k=300",      0);
    run_k(77,         "R1 k=77",       0);
    run_k(640,        "R7 k=640",      0);
    run_k(5,          "R9 k=5 stray",  1);

    // R9: no second run started by the stray pulse
    repeat (10) @(negedge clk);
    check(busy == 0, "R9", "busy after stray start", int'(busy), 0);
    check(exp_q.size() == 0, "R8", "pending results", exp_q.size(), 0);
    // R8: results hold while idle
    check(res_x == 8'd5, "R8", "res_x held", int'(res_x), 5);

    if (!finished) begin
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule